// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a bus master and a small register file that stands for a peripheral register region. It gives every bit of that register file a word address of its own in a separate alias window. A store to an alias word becomes an internally sequenced, atomic read-modify-write that changes exactly one bit. A load from an alias word returns that one bit, zero-extended. Software can then treat a single pin as if it were a whole variable.

Any address outside the alias window goes straight to the register file as an ordinary full-word access. The master uses a simple request/ready handshake. It holds `req` and its qualifiers until `ready` pulses for one cycle. During an alias store the master is held off until both internal cycles have completed, so no other access can fall between the read and the write of the target word.

Top module: `bitband_xlat`

## Requirements
- R1: After reset `ready` and `rdata` are 0 and every register word reads as 0.
- R2: A write to an address outside the alias window stores all 32 bits of `wdata` in word `addr[IDX_W+1:2]`, where IDX_W = log2(NWORDS). `ready` pulses one cycle after acceptance with `rdata` equal to 0.
- R3: A read from an address outside the alias window returns that word on `rdata` in the single cycle `ready` is high, one cycle after acceptance.
- R4: The alias window covers ALIAS_BASE (default 0x4200_0000) up to ALIAS_BASE + NWORDS*128 - 1. For offset = addr - ALIAS_BASE, the word is offset[IDX_W+6:7] and the bit is offset[6:2]. This is the same as base + target byte offset * 32 + bit-in-byte * 4.
- R5: An alias write sets the addressed bit to `wdata[0]`. Bits 31:1 of `wdata` are ignored, and every other bit of the register file keeps its value.
- R6: An alias write takes one cycle to read the target word and one cycle to write it back. `ready` pulses three cycles after acceptance.
- R7: An alias read returns the addressed bit in `rdata[0]` with `rdata[31:1]` equal to 0, and `ready` pulses one cycle after acceptance.
- R8: `ready` is never high for two cycles in a row. `rdata` is 0 whenever `ready` is low. A request is never accepted in the cycle `ready` is high.
- R9: While an alias write sequence is running, no request is accepted. A read issued right after the sequence sees the updated word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with `ready` |

## Verification
Two functions can fall in the same cycle: the write-back cycle of an alias read-modify-write, and a master request that is still being held on the bus. The bench keeps each alias store request asserted through both internal cycles. It then issues a plain read of the same word immediately afterwards. A cycle-accurate behavioural model flags any acceptance during the sequence, and the read-back must show only the one bit changed. Single-bit changes across a whole word, along with the window edges just inside and just outside, are judged in the same way against the model.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RMW_RD = 2'd1,
        ST_RMW_WR = 2'd2
    } bb_state_e;
endpackage

// File: rtl/bb_decode.sv
// Splits a bus address into alias / plain and derives word and bit index.
module bb_decode #(
    parameter int          NWORDS     = 16,
    parameter logic [31:0] ALIAS_BASE = 32'h4200_0000
) (
    input  logic [31:0]                 addr,
    output logic                        is_alias,
    output logic [$clog2(NWORDS)-1:0]   word_idx,
    output logic [4:0]                  bit_idx
);
    localparam int          IDX_W = $clog2(NWORDS);
    localparam logic [31:0] SPAN  = 32'(NWORDS * 128);

    logic [31:0] off;

    assign off      = addr - ALIAS_BASE;
    assign is_alias = (addr >= ALIAS_BASE) && (off < SPAN);
    assign word_idx = is_alias ? off[IDX_W+6:7] : addr[IDX_W+1:2];
    assign bit_idx  = is_alias ? off[6:2] : 5'd0;
endmodule

// File: rtl/bb_bitmerge.sv
// Replaces one selected bit of a word with a new value.
module bb_bitmerge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         din,
    input  logic [$clog2(DATA_W)-1:0] sel,
    input  logic                      val,
    output logic [DATA_W-1:0]         dout
);
    localparam int SEL_W = $clog2(DATA_W);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign dout[b] = (sel == SEL_W'(b)) ? val : din[b];
    end
endmodule

// File: rtl/bb_regfile.sv
// Target register file: one combinational read port, one write port.
module bb_regfile #(
    parameter int NWORDS = 16,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NWORDS)-1:0] rd_idx,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [$clog2(NWORDS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]         wr_data
);
    logic [DATA_W-1:0] mem_d [NWORDS];
    logic [DATA_W-1:0] mem_q [NWORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/bitband_xlat.sv
module bitband_xlat
    import bb_pkg::*;
#(
    parameter int          NWORDS     = 16,
    parameter logic [31:0] ALIAS_BASE = 32'h4200_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic        ready,
    output logic [31:0] rdata
);
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int BIT_W  = $clog2(DATA_W);

    typedef struct packed {
        bb_state_e          st;
        logic               ready;
        logic [DATA_W-1:0]  rdata;
        logic [IDX_W-1:0]   idx;
        logic [BIT_W-1:0]   bitn;
        logic               bitval;
        logic [DATA_W-1:0]  hold;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              dec_alias;
    logic [IDX_W-1:0]  dec_idx;
    logic [BIT_W-1:0]  dec_bit;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] merged;
    logic              accept;
    bb_state_e         state_q;
    logic [DATA_W-1:0] hold_q;

    bb_decode #(.NWORDS(NWORDS), .ALIAS_BASE(ALIAS_BASE)) u_dec (
        .addr     (addr),
        .is_alias (dec_alias),
        .word_idx (dec_idx),
        .bit_idx  (dec_bit)
    );

    bb_regfile #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_word),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    bb_bitmerge #(.DATA_W(DATA_W)) u_merge (
        .din  (regs_q.hold),
        .sel  (regs_q.bitn),
        .val  (regs_q.bitval),
        .dout (merged)
    );

    assign state_q = regs_q.st;
    assign hold_q  = regs_q.hold;
    assign accept  = req && (regs_q.st == ST_IDLE) && !regs_q.ready;

    always_comb begin
        regs_d       = regs_q;
        regs_d.ready = 1'b0;
        regs_d.rdata = '0;
        rd_idx       = (regs_q.st == ST_RMW_RD) ? regs_q.idx : dec_idx;
        wr_en        = 1'b0;
        wr_idx       = dec_idx;
        wr_data      = wdata;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_alias && we) begin
                        regs_d.st     = ST_RMW_RD;
                        regs_d.idx    = dec_idx;
                        regs_d.bitn   = dec_bit;
                        regs_d.bitval = wdata[0];
                    end else if (dec_alias) begin
                        regs_d.ready = 1'b1;
                        regs_d.rdata = {{(DATA_W-1){1'b0}}, rd_word[dec_bit]};
                    end else begin
                        regs_d.ready = 1'b1;
                        if (we) begin
                            wr_en = 1'b1;
                        end else begin
                            regs_d.rdata = rd_word;
                        end
                    end
                end
            end
            ST_RMW_RD: begin
                regs_d.hold = rd_word;
                regs_d.st   = ST_RMW_WR;
            end
            ST_RMW_WR: begin
                wr_en        = 1'b1;
                wr_idx       = regs_q.idx;
                wr_data      = merged;
                regs_d.st    = ST_IDLE;
                regs_d.ready = 1'b1;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, ready: 1'b0, rdata: '0, idx: '0,
                        bitn: '0, bitval: 1'b0, hold: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ready = regs_q.ready;
    assign rdata = regs_q.rdata;
endmodule

// File: rtl/bitband_xlat_chk.sv
module bitband_xlat_chk
    import bb_pkg::*;
#(
    parameter int          NWORDS     = 16,
    parameter logic [31:0] ALIAS_BASE = 32'h4200_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        we,
    input logic [31:0] addr,
    input logic        ready,
    input logic [31:0] rdata,
    input bb_state_e   st,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] hold
);
    localparam logic [31:0] SPAN = 32'(NWORDS * 128);

    logic in_win, acc, alias_rd_q;

    assign in_win = (addr >= ALIAS_BASE) && ((addr - ALIAS_BASE) < SPAN);
    assign acc    = req && (st == ST_IDLE) && !ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alias_rd_q <= 1'b0;
        else        alias_rd_q <= acc && in_win && !we;
    end

    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (rdata == 32'd0));
    p_alias_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_win && we) |=> (st == ST_RMW_RD));
    p_rd_then_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RMW_RD) |=> (st == ST_RMW_WR));
    p_wr_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RMW_WR) |=> (ready && st == ST_IDLE));
    p_held_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> !ready);
    p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RMW_WR && wr_en) |-> ($countones(wr_data ^ hold) <= 1));
    p_alias_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && alias_rd_q) |-> (rdata[31:1] == 31'd0));
endmodule

bind bitband_xlat bitband_xlat_chk #(.NWORDS(NWORDS), .ALIAS_BASE(ALIAS_BASE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .ready   (ready),
    .rdata   (rdata),
    .st      (state_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .hold    (hold_q)
);

// File: tb/bitband_xlat_tb.sv
`timescale 1ns/1ps
module bitband_xlat_tb;
    localparam int          NW   = 16;
    localparam logic [31:0] BASE = 32'h4200_0000;
    localparam logic [31:0] TGT  = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ready;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    bitband_xlat #(.NWORDS(NW), .ALIAS_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ready(ready), .rdata(rdata)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] ref_mem [NW];
    logic        exp_ready;
    logic [31:0] exp_rdata;
    int          m_wait;
    string       m_tag;

    function automatic bit in_win(logic [31:0] a);
        longint off;
        off = longint'(a) - longint'(BASE);
        return (off >= 0) && (off < NW * 128);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) ref_mem[i] = '0;
            exp_ready = 1'b0; exp_rdata = '0; m_wait = 0; m_tag = "R1";
        end else if (m_wait > 0) begin
            m_wait--;
            exp_ready = (m_wait == 0);
            exp_rdata = '0;
        end else if (exp_ready) begin
            exp_ready = 1'b0; exp_rdata = '0; // R8: no accept in ready cycle
        end else if (req) begin
            if (in_win(addr)) begin
                int off, w, b;
                off = int'(addr - BASE);
                w = off / 128;
                b = (off / 4) % 32;
                if (we) begin
                    ref_mem[w][b] = wdata[0];
                    m_wait = 2; exp_ready = 1'b0; exp_rdata = '0; m_tag = "R6";
                end else begin
                    exp_ready = 1'b1;
                    exp_rdata = {31'd0, ref_mem[w][b]}; m_tag = "R7";
                end
            end else begin
                int w;
                w = int'((addr / 4) % NW);
                exp_ready = 1'b1;
                if (we) begin
                    ref_mem[w] = wdata; exp_rdata = '0; m_tag = "R2";
                end else begin
                    exp_rdata = ref_mem[w]; m_tag = "R3";
                end
            end
        end else begin
            exp_ready = 1'b0; exp_rdata = '0;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (ready !== exp_ready || rdata !== exp_rdata) begin
                n_fail++;
                $display("FAIL %s/R8 model: ready=%0b rdata=%h expected ready=%0b rdata=%h",
                         m_tag, ready, rdata, exp_ready, exp_rdata);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] r, output int lat);
        req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ready && lat < 50);
        r = rdata;
        req = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] alias_of(int word, int bitn);
        return BASE + 32'(word * 128 + bitn * 4);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int lat;
        logic [31:0] pat;

        repeat (3) @(negedge clk);
        check("R1 ready", {31'd0, ready}, 32'd0);
        check("R1 rdata", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        xfer(0, TGT, 0, r, lat);            check("R1 word0", r, 32'd0);
        xfer(0, TGT + 32'h3C, 0, r, lat);   check("R1 word15", r, 32'd0);

        // R2 / R3 plain path
        xfer(1, TGT, 32'h1234_5678, r, lat);
        check("R2 write latency", 32'(lat), 32'd1);
        check("R2 write rdata", r, 32'd0);
        xfer(0, TGT, 0, r, lat);
        check("R3 readback", r, 32'h1234_5678);
        check("R3 latency", 32'(lat), 32'd1);

        // R5 / R6 alias set on word 5
        xfer(1, TGT + 32'h14, 32'hFFFF_0000, r, lat);
        xfer(1, 32'h4200_0280, 32'h0000_0001, r, lat);
        check("R6 alias write latency", 32'(lat), 32'd3);
        xfer(0, TGT + 32'h14, 0, r, lat);   // R9: read right after RMW
        check("R9 post-rmw read", r, 32'hFFFF_0001);

        // R5 clear bit 31, upper data bits ignored
        xfer(1, 32'h4200_02FC, 32'hFFFF_FFFE, r, lat);
        xfer(0, TGT + 32'h14, 0, r, lat);
        check("R5 clear bit31", r, 32'h7FFF_0001);
        xfer(1, alias_of(5, 0), 32'h0000_0003, r, lat);
        xfer(0, TGT + 32'h14, 0, r, lat);
        check("R5 set already-set", r, 32'h7FFF_0001);

        // R7 / R4 alias reads; byte 0x16 bit 0 -> base + 0x16*32
        xfer(0, BASE + 32'h16 * 32, 0, r, lat);
        check("R4 byte-offset form bit16", r, 32'd1);
        check("R7 alias read latency", 32'(lat), 32'd1);
        xfer(0, alias_of(5, 15), 0, r, lat);
        check("R7 alias read clear bit", r, 32'd0);

        // R4 last alias word
        xfer(1, BASE + 32'h7FC, 32'd1, r, lat);
        xfer(0, TGT + 32'h3C, 0, r, lat);
        check("R4 top of window", r, 32'h8000_0000);

        // R2 just past window: plain, word 0
        xfer(1, BASE + 32'h800, 32'hCAFE_F00D, r, lat);
        check("R2 past window latency", 32'(lat), 32'd1);
        xfer(0, TGT, 0, r, lat);
        check("R2 past window word0", r, 32'hCAFE_F00D);
        xfer(0, BASE - 32'd4, 0, r, lat);
        check("R3 below window word15", r, 32'h8000_0000);

        // R5 walk every bit of word 3
        xfer(1, TGT + 32'h0C, 32'h0F0F_0F0F, r, lat);
        pat = 32'h0F0F_0F0F;
        for (int i = 0; i < 32; i++) begin
            logic v;
            v = (i % 3 == 0);
            pat[i] = v;
            xfer(1, alias_of(3, i), {31'h5A5A_5A5A, v}, r, lat);
        end
        xfer(0, TGT + 32'h0C, 0, r, lat);
        check("R5 bit walk word3", r, pat);
        xfer(0, TGT + 32'h14, 0, r, lat);
        check("R5 neighbour word5 intact", r, 32'h7FFF_0001);
        for (int i = 0; i < 32; i++) begin
            xfer(0, alias_of(3, i), 0, r, lat);
            check("R7 bit walk read", r, {31'd0, pat[i]});
        end

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule